// File: doc/BRIEF.md
# Postfix Stack Arithmetic Unit

This block keeps a small hardware stack of wide words and executes postfix commands on it. A producer issues one command per ready/valid handshake. A command can load an external value onto the stack, combine the two upper entries arithmetically (sum or product), or rearrange entries by copying, exchanging or discarding them. Operands are never addressed. Every arithmetic command consumes its inputs from the top of the stack and leaves its result there.

The word width is set in bytes, and the stack holds a parameterised number of entries. The unit always shows the current top entry, the number of occupied entries and a carry bit from the latest arithmetic command. A command that needs more entries than are present, or that would grow the stack past its capacity, is rejected. A rejected command leaves every entry, the depth and the carry as they were, and raises an error indication. Multiplication runs one bit per cycle and holds the command port off until its result has been written.

Top module: `stack_alu`

## Requirements
- R1: After reset, depth is 0, the top-of-stack output reads 0, carry and error are 0, and `cmd_ready` is 1.
- R2: Command code 0 (load) places `cmd_data` on top and raises depth by one. Whenever depth is 0, the top-of-stack output reads 0.
- R3: Command code 1 (sum) replaces the two upper entries with their sum modulo 2^W, where W is 8·WORD_BYTES. Carry takes the carry out of the sum, and depth falls by one.
- R4: Command code 2 with `cmd_wide`=0 replaces the two upper entries with the low W bits of their product. Carry is set exactly when the upper W bits of the product are nonzero, and depth falls by one.
- R5: Command code 2 with `cmd_wide`=1 keeps depth unchanged. The second entry becomes the low half of the full product, the top entry becomes the high half, and carry is cleared.
- R6: After a legal multiply is accepted, `cmd_ready` stays 0 for exactly W+1 clock cycles. Depth and the top-of-stack output do not change while it is 0.
- R7: Command code 3 pushes a copy of the top entry. Command code 4 pushes a copy of the entry just below the top.
- R8: Command code 5 exchanges the two upper entries. Command code 6 removes the top entry.
- R9: Command code 7 pushes a copy of the entry `cmd_idx` positions below the top. Index 0 means the top entry itself.
- R10: A command is refused when depth is smaller than its operand need, or when it pushes while depth equals DEPTH. Operand needs are: 2 for codes 1, 2, 4 and 5; 1 for codes 3 and 6; `cmd_idx`+1 for code 7. A refused command sets `err` to 1, changes no entry, depth or carry, and never drops `cmd_ready`. `err` is updated on every accepted command and returns to 0 on the next legal one.
- R11: Carry changes only on a completed sum or multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_op | input | 3 | Command code (0 load, 1 sum, 2 multiply, 3 copy top, 4 copy second, 5 exchange, 6 discard, 7 copy indexed) |
| cmd_wide | input | 1 | Multiply keeps the full double-width product |
| cmd_idx | input | $clog2(DEPTH) | Entry index for the indexed copy, 0 = top |
| cmd_data | input | 8·WORD_BYTES | Value for the load command |
| tos | output | 8·WORD_BYTES | Current top entry, 0 when empty |
| depth | output | $clog2(DEPTH+1) | Number of occupied entries |
| carry | output | 1 | Carry from the latest arithmetic command |
| err | output | 1 | Latest accepted command was refused |

## Verification
A wrong depth counter shows up at the next command: the top-of-stack output reads the wrong slot, or the next refusal decision goes the wrong way. The bench therefore compares depth, top, carry and error after every single command against its own stack model. Entries deeper than the top are visible only after they have been brought up. For this reason, each scenario ends by discarding entries one at a time, which exposes every buried value at the port within one command per entry. A fault in the multiplier sequencing appears as a stall count different from W+1, or as a wrong product half, on the first multiply.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_ADD  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DUP  = 3'd3,
        OP_OVER = 3'd4,
        OP_SWAP = 3'd5,
        OP_DROP = 3'd6,
        OP_PICK = 3'd7
    } sa_op_e;
endpackage

// File: rtl/sa_guard.sv
// Decides whether a command fits the current stack occupancy.
module sa_guard #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  sa_pkg::sa_op_e   op,
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] cur_depth,
    output logic             legal
);
    import sa_pkg::*;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W:0] need;
    logic           grows;

    always_comb begin
        need  = '0;
        grows = 1'b0;
        case (op)
            OP_PUSH: grows = 1'b1;
            OP_ADD:  need  = (CNT_W+1)'(2);
            OP_MUL:  need  = (CNT_W+1)'(2);
            OP_DUP:  begin need = (CNT_W+1)'(1); grows = 1'b1; end
            OP_OVER: begin need = (CNT_W+1)'(2); grows = 1'b1; end
            OP_SWAP: need  = (CNT_W+1)'(2);
            OP_DROP: need  = (CNT_W+1)'(1);
            OP_PICK: begin
                need  = (CNT_W+1)'(idx) + (CNT_W+1)'(1);
                grows = 1'b1;
            end
            default: need = '0;
        endcase
        legal = ({1'b0, cur_depth} >= need) && (!grows || (cur_depth < FULL));
    end
endmodule

// File: rtl/sa_mul.sv
// Shift-and-add multiplier, one multiplier bit per cycle.
module sa_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           done,
    output logic [2*W-1:0] prod
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [2*W-1:0] acc;
        logic [2*W-1:0] mcand;
        logic [W-1:0]   mplier;
        logic [CW-1:0]  cnt;
        logic           busy;
        logic           done;
    } mul_st_t;

    mul_st_t mul_d, mul_q;

    always_comb begin
        mul_d      = mul_q;
        mul_d.done = 1'b0;
        if (start) begin
            mul_d.acc    = '0;
            mul_d.mcand  = {{W{1'b0}}, a};
            mul_d.mplier = b;
            mul_d.cnt    = '0;
            mul_d.busy   = 1'b1;
        end else if (mul_q.busy) begin
            if (mul_q.mplier[0]) begin
                mul_d.acc = mul_q.acc + mul_q.mcand;
            end
            mul_d.mcand  = mul_q.mcand << 1;
            mul_d.mplier = mul_q.mplier >> 1;
            mul_d.cnt    = mul_q.cnt + CW'(1);
            if (mul_q.cnt == LAST) begin
                mul_d.busy = 1'b0;
                mul_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= '0;
        end else begin
            mul_q <= mul_d;
        end
    end

    assign done = mul_q.done;
    assign prod = mul_q.acc;
endmodule

// File: rtl/stack_alu.sv
module stack_alu #(
    parameter int WORD_BYTES = 4,
    parameter int DEPTH      = 8,
    localparam int W         = 8 * WORD_BYTES,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_wide,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [W-1:0]     cmd_data,
    output logic [W-1:0]     tos,
    output logic [CNT_W-1:0] depth,
    output logic             carry,
    output logic             err
);
    import sa_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stk;
        logic [CNT_W-1:0]        depth;
        logic                    carry;
        logic                    err;
        logic                    busy;
        logic                    wide;
    } sa_st_t;

    sa_st_t st_d, st_q;

    sa_op_e           op;
    logic             legal;
    logic [CNT_W-1:0] off_top, off_sec, off_pick;
    logic [IDX_W-1:0] top_i, sec_i, pick_i, push_i;
    logic [W-1:0]     top_v, sec_v, pick_v;
    logic [W:0]       sum;
    logic             mul_go, mul_done;
    logic [2*W-1:0]   mul_prod;

    assign op = sa_op_e'(cmd_op);

    // Slot pointers derived from the occupancy count.
    always_comb begin
        off_top  = st_q.depth - CNT_W'(1);
        off_sec  = st_q.depth - CNT_W'(2);
        off_pick = off_top - CNT_W'(cmd_idx);
        top_i    = off_top[IDX_W-1:0];
        sec_i    = off_sec[IDX_W-1:0];
        pick_i   = off_pick[IDX_W-1:0];
        push_i   = st_q.depth[IDX_W-1:0];
        top_v    = st_q.stk[top_i];
        sec_v    = st_q.stk[sec_i];
        pick_v   = st_q.stk[pick_i];
        sum      = {1'b0, sec_v} + {1'b0, top_v};
    end

    sa_guard #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_guard (
        .op        (op),
        .idx       (cmd_idx),
        .cur_depth (st_q.depth),
        .legal     (legal)
    );

    sa_mul #(
        .W (W)
    ) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_go),
        .a     (sec_v),
        .b     (top_v),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    always_comb begin
        st_d   = st_q;
        mul_go = 1'b0;
        if (st_q.busy) begin
            if (mul_done) begin
                st_d.busy       = 1'b0;
                st_d.stk[sec_i] = mul_prod[W-1:0];
                if (st_q.wide) begin
                    st_d.stk[top_i] = mul_prod[2*W-1:W];
                    st_d.carry      = 1'b0;
                end else begin
                    st_d.depth = st_q.depth - CNT_W'(1);
                    st_d.carry = |mul_prod[2*W-1:W];
                end
            end
        end else if (cmd_valid) begin
            st_d.err = !legal;
            if (legal) begin
                case (op)
                    OP_PUSH: begin
                        st_d.stk[push_i] = cmd_data;
                        st_d.depth       = st_q.depth + CNT_W'(1);
                    end
                    OP_ADD: begin
                        st_d.stk[sec_i] = sum[W-1:0];
                        st_d.carry      = sum[W];
                        st_d.depth      = st_q.depth - CNT_W'(1);
                    end
                    OP_MUL: begin
                        mul_go    = 1'b1;
                        st_d.busy = 1'b1;
                        st_d.wide = cmd_wide;
                    end
                    OP_DUP: begin
                        st_d.stk[push_i] = top_v;
                        st_d.depth       = st_q.depth + CNT_W'(1);
                    end
                    OP_OVER: begin
                        st_d.stk[push_i] = sec_v;
                        st_d.depth       = st_q.depth + CNT_W'(1);
                    end
                    OP_SWAP: begin
                        st_d.stk[sec_i] = top_v;
                        st_d.stk[top_i] = sec_v;
                    end
                    OP_DROP: begin
                        st_d.depth = st_q.depth - CNT_W'(1);
                    end
                    OP_PICK: begin
                        st_d.stk[push_i] = pick_v;
                        st_d.depth       = st_q.depth + CNT_W'(1);
                    end
                    default: st_d.err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready = !st_q.busy;
    assign tos       = (st_q.depth != '0) ? top_v : '0;
    assign depth     = st_q.depth;
    assign carry     = st_q.carry;
    assign err       = st_q.err;
endmodule

// File: rtl/sa_chk.sv
module sa_chk #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [W-1:0]     cmd_data,
    input logic [W-1:0]     tos,
    input logic [CNT_W-1:0] depth,
    input logic             carry,
    input logic             err
);
    import sa_pkg::*;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic   fire;
    sa_op_e op;
    assign fire = cmd_valid && cmd_ready;
    assign op   = sa_op_e'(cmd_op);

    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_PUSH && depth < FULL
        |=> depth == $past(depth) + CNT_W'(1) && tos == $past(cmd_data) && !err);

    // R10
    empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_DROP && depth == '0 |=> err && depth == '0);

    // R10
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_PUSH && depth == FULL |=> err && depth == FULL && $stable(tos));

    // R6
    mul_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_MUL && depth >= CNT_W'(2) |=> !cmd_ready);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> $stable(depth) && $stable(tos));

    // R11
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op != OP_ADD && op != OP_MUL |=> $stable(carry));

    // R7
    dup_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op == OP_DUP && depth != '0 && depth < FULL
        |=> tos == $past(tos) && depth == $past(depth) + CNT_W'(1));
endmodule

bind stack_alu sa_chk #(
    .W     (W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_sa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .tos       (tos),
    .depth     (depth),
    .carry     (carry),
    .err       (err)
);

// File: tb/tb_stack_alu.sv
module tb_stack_alu;
    localparam int W     = 32;
    localparam int DEPTH = 8;
    localparam int CNT_W = 4;
    localparam int IDX_W = 3;

    localparam logic [2:0] C_PUSH = 3'd0, C_ADD = 3'd1, C_MUL = 3'd2, C_DUP = 3'd3,
                           C_OVER = 3'd4, C_SWAP = 3'd5, C_DROP = 3'd6, C_PICK = 3'd7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [2:0]       cmd_op = '0;
    logic             cmd_wide = 1'b0;
    logic [IDX_W-1:0] cmd_idx = '0;
    logic [W-1:0]     cmd_data = '0;
    logic [W-1:0]     tos;
    logic [CNT_W-1:0] depth;
    logic             carry;
    logic             err;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    // bench stack model
    logic [W-1:0] m [0:DEPTH-1];
    int           md = 0;
    logic         mc = 1'b0;
    logic         me = 1'b0;
    int           stall = 0;

    always #5 clk = ~clk;

    stack_alu #(.WORD_BYTES(4), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_wide(cmd_wide), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
        .tos(tos), .depth(depth), .carry(carry), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        logic [W-1:0] et;
        et = (md > 0) ? m[md-1] : '0;
        chk(tos === et, {tag, " tos"}, 64'(tos), 64'(et));
        chk(depth === CNT_W'(md), {tag, " depth"}, 64'(depth), 64'(md));
        chk(carry === mc, {tag, " carry"}, 64'(carry), 64'(mc));
        chk(err === me, {tag, " err"}, 64'(err), 64'(me));
    endtask

    task automatic model(input logic [2:0] op, input logic wide, input int idx, input logic [W-1:0] data);
        int need;
        bit grow;
        logic [W:0] s;
        logic [2*W-1:0] p;
        need = 0; grow = 0;
        case (op)
            C_PUSH: grow = 1;
            C_ADD, C_MUL, C_SWAP: need = 2;
            C_DUP: begin need = 1; grow = 1; end
            C_OVER: begin need = 2; grow = 1; end
            C_DROP: need = 1;
            default: begin need = idx + 1; grow = 1; end
        endcase
        if (md < need || (grow && md == DEPTH)) begin
            me = 1'b1;
            return;
        end
        me = 1'b0;
        case (op)
            C_PUSH: begin m[md] = data; md++; end
            C_ADD: begin
                s = {1'b0, m[md-2]} + {1'b0, m[md-1]};
                m[md-2] = s[W-1:0]; mc = s[W]; md--;
            end
            C_MUL: begin
                p = {{W{1'b0}}, m[md-2]} * {{W{1'b0}}, m[md-1]};
                if (wide) begin
                    m[md-2] = p[W-1:0]; m[md-1] = p[2*W-1:W]; mc = 1'b0;
                end else begin
                    m[md-2] = p[W-1:0]; mc = |p[2*W-1:W]; md--;
                end
            end
            C_DUP: begin m[md] = m[md-1]; md++; end
            C_OVER: begin m[md] = m[md-2]; md++; end
            C_SWAP: begin s[W-1:0] = m[md-1]; m[md-1] = m[md-2]; m[md-2] = s[W-1:0]; end
            C_DROP: md--;
            default: begin m[md] = m[md-1-idx]; md++; end
        endcase
    endtask

    task automatic issue(input logic [2:0] op, input logic wide, input int idx,
                         input logic [W-1:0] data, input string tag);
        model(op, wide, idx, data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wide = wide;
        cmd_idx = IDX_W'(idx); cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        stall = 0;
        while (!cmd_ready) begin
            @(negedge clk);
            stall++;
        end
        check_state(tag);
    endtask

    task automatic drain(input string tag);
        while (md > 0) issue(C_DROP, 1'b0, 0, '0, tag);
    endtask

    task automatic t_reset;
        chk(cmd_ready === 1'b1, "R1 ready", 64'(cmd_ready), 64'd1);
        check_state("R1");
    endtask

    task automatic t_push;
        issue(C_PUSH, 1'b0, 0, 32'h11, "R2");
        issue(C_PUSH, 1'b0, 0, 32'hDEADBEEF, "R2");
        issue(C_PUSH, 1'b0, 0, 32'h0, "R2");
        drain("R2 drain");
    endtask

    task automatic t_add;
        issue(C_PUSH, 1'b0, 0, 32'd5, "R3");
        issue(C_PUSH, 1'b0, 0, 32'd3, "R3");
        issue(C_ADD, 1'b0, 0, '0, "R3 small");
        issue(C_PUSH, 1'b0, 0, 32'hFFFFFFFF, "R3");
        issue(C_ADD, 1'b0, 0, '0, "R3 wrap");
        drain("R11 drain keeps carry");
        issue(C_PUSH, 1'b0, 0, 32'd1, "R3");
        issue(C_PUSH, 1'b0, 0, 32'd2, "R3");
        issue(C_ADD, 1'b0, 0, '0, "R3 clear carry");
        drain("R3 drain");
    endtask

    task automatic t_mul;
        issue(C_PUSH, 1'b0, 0, 32'd7, "R4");
        issue(C_PUSH, 1'b0, 0, 32'd6, "R4");
        issue(C_MUL, 1'b0, 0, '0, "R4 small");
        chk(stall == W + 1, "R6 stall", 64'(stall), 64'(W + 1));
        issue(C_PUSH, 1'b0, 0, 32'h0001_0000, "R4");
        issue(C_PUSH, 1'b0, 0, 32'h0001_0000, "R4");
        issue(C_MUL, 1'b0, 0, '0, "R4 overflow");
        drain("R4 drain");
        issue(C_PUSH, 1'b0, 0, 32'hFFFFFFFF, "R5");
        issue(C_PUSH, 1'b0, 0, 32'hFFFFFFFF, "R5");
        issue(C_MUL, 1'b1, 0, '0, "R5 max");
        chk(stall == W + 1, "R6 stall wide", 64'(stall), 64'(W + 1));
        drain("R5 low half");
        issue(C_PUSH, 1'b0, 0, 32'h12345678, "R5");
        issue(C_PUSH, 1'b0, 0, 32'h9ABCDEF0, "R5");
        issue(C_MUL, 1'b1, 0, '0, "R5 mixed");
        drain("R5 low half");
    endtask

    task automatic t_stack;
        issue(C_PUSH, 1'b0, 0, 32'hA1, "R7");
        issue(C_PUSH, 1'b0, 0, 32'hB2, "R7");
        issue(C_DUP, 1'b0, 0, '0, "R7 dup");
        issue(C_PUSH, 1'b0, 0, 32'hC3, "R7");
        issue(C_OVER, 1'b0, 0, '0, "R7 over");
        issue(C_SWAP, 1'b0, 0, '0, "R8 swap");
        issue(C_DROP, 1'b0, 0, '0, "R8 drop");
        issue(C_PICK, 1'b0, 0, '0, "R9 pick0");
        issue(C_PICK, 1'b0, 2, '0, "R9 pick2");
        issue(C_PICK, 1'b0, md - 1, '0, "R9 deepest");
        drain("R8 drain");
    endtask

    task automatic t_refuse;
        issue(C_DROP, 1'b0, 0, '0, "R10 empty drop");
        issue(C_PUSH, 1'b0, 0, 32'h55, "R10 clear");
        issue(C_ADD, 1'b0, 0, '0, "R10 short add");
        issue(C_MUL, 1'b0, 0, '0, "R10 short mul");
        chk(stall == 0, "R10 no stall", 64'(stall), 64'd0);
        issue(C_PUSH, 1'b0, 0, 32'h66, "R10");
        issue(C_PUSH, 1'b0, 0, 32'h77, "R10");
        issue(C_PICK, 1'b0, 3, '0, "R10 deep pick");
        for (int i = 0; i < 5; i++) issue(C_PUSH, 1'b0, 0, 32'(i + 1), "R10 fill");
        issue(C_PUSH, 1'b0, 0, 32'h99, "R10 full push");
        issue(C_DUP, 1'b0, 0, '0, "R10 full dup");
        issue(C_SWAP, 1'b0, 0, '0, "R10 full swap");
        drain("R10 drain");
    endtask

    task automatic t_carry;
        issue(C_PUSH, 1'b0, 0, 32'h8000_0000, "R11");
        issue(C_PUSH, 1'b0, 0, 32'h8000_0000, "R11");
        issue(C_ADD, 1'b0, 0, '0, "R11 set");
        issue(C_DUP, 1'b0, 0, '0, "R11 dup");
        issue(C_SWAP, 1'b0, 0, '0, "R11 swap");
        issue(C_PICK, 1'b0, 1, '0, "R11 pick");
        issue(C_DROP, 1'b0, 0, '0, "R11 drop");
        drain("R11 drain");
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R6 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push();
        t_add();
        t_mul();
        t_stack();
        t_refuse();
        t_carry();
        finish_run();
    end
endmodule